// File: doc/BRIEF.md
# Interrupt Pending/Enable Arbiter

This block keeps the pending and enable bit vectors for a core's interrupt causes. Each cycle it screens them against three global enable inputs, one per privilege level, and reports from a register whether an interrupt should be taken and which cause it is. Hardware sources raise or drop single pending bits with strobes that carry a cause number. A clear-all strobe drops every pending bit at once. Software reads and overwrites the whole pending word and the whole enable word through plain write-enable ports.

The causes sit in three groups of three. Each privilege level owns a software, a timer and an external cause. A cause's position is its number, which is the value reported on the cause output. When several causes qualify at once, the lowest-numbered one is reported.

No port carries a data stream. Every strobe and every write is accepted in the cycle it is presented, so the block never applies back-pressure and has no valid/ready pairs.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pending word, the enable word, `irq_take` and `irq_cause` are all zero.
- R2: Only bit positions 0, 1, 3, 4, 5, 7, 8, 9 and 11 are implemented. Every other position reads as zero in both words and ignores strobes and writes, so the implemented mask is 12'hBBB.
- R3: `post_valid` sets pending bit `post_cause` and `clr_valid` clears pending bit `clr_cause`. `clr_all` zeroes the pending word. Precedence, from highest to lowest: the single-bit clear, then the post, then clear-all. Each change is visible on `ip_rdata` after the next clock edge.
- R4: A write with `ip_we` or `ie_we` loads the whole word, and the new value shows on `ip_rdata` or `ie_rdata` after the next clock edge. The enable word changes only through `ie_we`.
- R5: When a pending-word write arrives in the same cycle as a post or single-bit clear strobe, the strobe decides the value of the bit it addresses. The write decides all other bits.
- R6: `glb_u` unmasks causes 0, 4 and 8. `glb_s` unmasks causes 1, 5 and 9. `glb_m` unmasks causes 3, 7 and 11.
- R7: A cause is eligible when its pending bit, its enable bit and its group's global enable are all 1. `irq_take` is the OR of all eligible causes. It is registered: it reflects the stored words and the global enables as they were before the clock edge that updates it.
- R8: `irq_cause` reports the lowest-numbered eligible cause, registered like `irq_take`. When no cause is eligible it reads 0 and `irq_take` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Set one pending bit |
| post_cause | input | CW | Cause number to set |
| clr_valid | input | 1 | Clear one pending bit |
| clr_cause | input | CW | Cause number to clear |
| clr_all | input | 1 | Zero the pending word |
| ip_we | input | 1 | Software write of the pending word |
| ip_wdata | input | N | Pending word write data |
| ip_rdata | output | N | Current pending word |
| ie_we | input | 1 | Software write of the enable word |
| ie_wdata | input | N | Enable word write data |
| ie_rdata | output | N | Current enable word |
| glb_m | input | 1 | Machine-level global enable |
| glb_s | input | 1 | Supervisor-level global enable |
| glb_u | input | 1 | User-level global enable |
| irq_take | output | 1 | An eligible cause exists |
| irq_cause | output | CW | Lowest eligible cause number |

## Verification
A strobe or write presented before clock edge k changes `ip_rdata` and `ie_rdata` right after edge k. It reaches `irq_take` and `irq_cause` only after edge k+1. A change on a global enable reaches the outputs after the very next edge. The driver computes the outputs due at the coming edge from its model of the stored words and the enable levels it drives. It also computes the stored words due after that edge. It queues both, and the monitor pops and compares them one time unit after that edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // Privilege group of a cause position: slot 0 user, 1 supervisor, 3 machine.
  typedef enum logic [1:0] {GRP_USER = 2'd0, GRP_SUPV = 2'd1, GRP_NONE = 2'd2, GRP_MACH = 2'd3} grp_e;

  localparam int unsigned CAUSE_LIMIT = 12;

  function automatic grp_e grp_of(input int unsigned idx);
    if (idx >= CAUSE_LIMIT) return GRP_NONE;
    return grp_e'(idx % 4);
  endfunction

  function automatic bit is_impl(input int unsigned idx);
    return grp_of(idx) != GRP_NONE;
  endfunction
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int unsigned N  = 12,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_v,
  input  logic [CW-1:0] post_c,
  input  logic          clr_v,
  input  logic [CW-1:0] clr_c,
  input  logic          clr_all,
  input  logic          we,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  impl,
  output logic [N-1:0]  q
);
  logic [N-1:0] nxt;

  always_comb begin
    nxt = we ? wdata : q;
    if (clr_all) nxt = '0;
    for (int i = 0; i < N; i++) begin
      if (post_v && (int'(post_c) == i)) nxt[i] = 1'b1;
      if (clr_v && (int'(clr_c) == i))   nxt[i] = 1'b0;
    end
    nxt = nxt & impl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_en_store.sv
module irq_en_store #(
  parameter int unsigned N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] impl,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & impl;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned N  = 12,
  parameter int unsigned CW = 4
) (
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [CW-1:0] idx
);
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = CW'(i);
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N = 12,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_valid,
  input  logic [CW-1:0] post_cause,
  input  logic          clr_valid,
  input  logic [CW-1:0] clr_cause,
  input  logic          clr_all,
  input  logic          ip_we,
  input  logic [N-1:0]  ip_wdata,
  output logic [N-1:0]  ip_rdata,
  input  logic          ie_we,
  input  logic [N-1:0]  ie_wdata,
  output logic [N-1:0]  ie_rdata,
  input  logic          glb_m,
  input  logic          glb_s,
  input  logic          glb_u,
  output logic          irq_take,
  output logic [CW-1:0] irq_cause
);
  import irq_arb_pkg::*;

  logic [N-1:0]  impl;
  logic [N-1:0]  gmask;
  logic [N-1:0]  elig;
  logic          pick_any;
  logic [CW-1:0] pick_idx;

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam grp_e GRP = grp_of(g);
    assign impl[g] = (GRP != GRP_NONE);
    if (GRP == GRP_MACH) begin : g_m
      assign gmask[g] = glb_m;
    end else if (GRP == GRP_SUPV) begin : g_s
      assign gmask[g] = glb_s;
    end else if (GRP == GRP_USER) begin : g_u
      assign gmask[g] = glb_u;
    end else begin : g_x
      assign gmask[g] = 1'b0;
    end
  end

  irq_pend_store #(.N(N), .CW(CW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .post_v(post_valid), .post_c(post_cause),
    .clr_v(clr_valid), .clr_c(clr_cause), .clr_all(clr_all),
    .we(ip_we), .wdata(ip_wdata), .impl(impl), .q(ip_rdata)
  );

  irq_en_store #(.N(N)) u_en (
    .clk(clk), .rst_n(rst_n), .we(ie_we), .wdata(ie_wdata),
    .impl(impl), .q(ie_rdata)
  );

  assign elig = ip_rdata & ie_rdata & gmask;

  irq_lowest_pick #(.N(N), .CW(CW)) u_pick (
    .elig(elig), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_take  <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_take  <= pick_any;
      irq_cause <= pick_idx;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int unsigned N  = 12,
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          post_valid,
  input logic [CW-1:0] post_cause,
  input logic          clr_valid,
  input logic [CW-1:0] clr_cause,
  input logic          ie_we,
  input logic [N-1:0]  ip_rdata,
  input logic [N-1:0]  ie_rdata,
  input logic          glb_m,
  input logic          glb_s,
  input logic          glb_u,
  input logic          irq_take,
  input logic [CW-1:0] irq_cause
);
  import irq_arb_pkg::*;

  logic [N-1:0]  ok_pos;
  logic [N-1:0]  lvl;
  logic [N-1:0]  elig_q;
  logic          post_hit_q;
  logic [CW-1:0] post_c_q;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ok_pos[i] = is_impl(i);
      case (grp_of(i))
        GRP_MACH: lvl[i] = glb_m;
        GRP_SUPV: lvl[i] = glb_s;
        GRP_USER: lvl[i] = glb_u;
        default:  lvl[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elig_q     <= '0;
      post_hit_q <= 1'b0;
      post_c_q   <= '0;
    end else begin
      elig_q     <= ip_rdata & ie_rdata & lvl;
      post_hit_q <= post_valid && (int'(post_cause) < N) && is_impl(int'(post_cause))
                    && !(clr_valid && clr_cause == post_cause);
      post_c_q   <= post_cause;
    end
  end

  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((ip_rdata | ie_rdata) & ~ok_pos) == '0);
  a_r3_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    post_hit_q |-> ip_rdata[post_c_q]);
  a_r4_ie_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_we |=> $stable(ie_rdata));
  a_r7_take_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take == (|elig_q));
  a_r8_cause_elig: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> elig_q[irq_cause]);
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ((elig_q & ((N'(1) << irq_cause) - N'(1))) == '0));
  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take |-> irq_cause == '0);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_cause(post_cause),
  .clr_valid(clr_valid), .clr_cause(clr_cause), .ie_we(ie_we),
  .ip_rdata(ip_rdata), .ie_rdata(ie_rdata), .glb_m(glb_m), .glb_s(glb_s),
  .glb_u(glb_u), .irq_take(irq_take), .irq_cause(irq_cause)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  localparam int N  = 12;
  localparam int CW = 4;
  localparam logic [N-1:0] IMPL = 12'hBBB;
  localparam logic [N-1:0] GU = 12'h111, GS = 12'h222, GM = 12'h888;

  logic clk = 0, rst_n = 0;
  logic post_valid = 0, clr_valid = 0, clr_all = 0, ip_we = 0, ie_we = 0;
  logic [CW-1:0] post_cause = 0, clr_cause = 0;
  logic [N-1:0] ip_wdata = 0, ie_wdata = 0, ip_rdata, ie_rdata;
  logic glb_m = 0, glb_s = 0, glb_u = 0, irq_take;
  logic [CW-1:0] irq_cause;

  int checks = 0, errors = 0;

  typedef struct {
    logic take; logic [CW-1:0] cause; logic [N-1:0] ip; logic [N-1:0] ie; string tag;
  } exp_t;
  exp_t sbq[$];
  logic [N-1:0] m_ip = 0, m_ie = 0;

  always #10 clk = ~clk;

  irq_arbiter #(.N(N)) u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit pv, input int pc, input bit cv, input int cc, input bit ca,
                      input bit iw, input logic [N-1:0] iv, input bit ew, input logic [N-1:0] ev,
                      input bit m, input bit s, input bit u, input string tag);
    exp_t e;
    logic [N-1:0] el, nip;
    @(negedge clk);
    post_valid = pv; post_cause = CW'(pc); clr_valid = cv; clr_cause = CW'(cc);
    clr_all = ca; ip_we = iw; ip_wdata = iv; ie_we = ew; ie_wdata = ev;
    glb_m = m; glb_s = s; glb_u = u;
    el = m_ip & m_ie & ((m ? GM : '0) | (s ? GS : '0) | (u ? GU : '0));
    e.take = |el; e.cause = '0;
    for (int i = N - 1; i >= 0; i--) if (el[i]) e.cause = CW'(i);
    nip = iw ? iv : m_ip;
    if (ca) nip = '0;
    if (pv && pc < N) nip[pc] = 1'b1;
    if (cv && cc < N) nip[cc] = 1'b0;
    m_ip = nip & IMPL;
    if (ew) m_ie = ev & IMPL;
    e.ip = m_ip; e.ie = m_ie; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input bit m, input bit s, input bit u, input string tag);
    step(0, 0, 0, 0, 0, 0, '0, 0, '0, m, s, u, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(e.tag, "irq_take", irq_take, e.take);
        chk(e.tag, "irq_cause", irq_cause, e.cause);
        chk(e.tag, "ip_rdata", ip_rdata, e.ip);
        chk(e.tag, "ie_rdata", ie_rdata, e.ie);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset take", irq_take, 0);
    chk("R1", "reset cause", irq_cause, 0);
    chk("R1", "reset ip", ip_rdata, 0);
    chk("R1", "reset ie", ie_rdata, 0);
    @(negedge clk); rst_n = 1;
    idle(0, 0, 0, "R1 post-reset");
    // R2/R4: enable write of all ones keeps only implemented slots
    step(0, 0, 0, 0, 0, 0, '0, 1, 12'hFFF, 0, 0, 0, "R2 R4 ie write");
    idle(0, 0, 0, "R4 ie readback");
    // R3/R7: post machine timer 7, machine enable on
    step(1, 7, 0, 0, 0, 0, '0, 0, '0, 1, 0, 0, "R3 post 7");
    idle(1, 0, 0, "R7 take cause 7");
    idle(1, 0, 0, "R7 steady");
    // R6: supervisor software 1 masked until glb_s
    step(1, 1, 0, 0, 0, 0, '0, 0, '0, 1, 0, 0, "R6 post 1");
    idle(1, 0, 0, "R6 s masked");
    idle(1, 1, 0, "R6 R8 s unmask lowest 1");
    idle(0, 1, 0, "R6 m off");
    // R2: unimplemented cause 2 ignored
    step(1, 2, 0, 0, 0, 0, '0, 0, '0, 1, 1, 1, "R2 post 2 ignored");
    step(1, 0, 0, 0, 0, 0, '0, 0, '0, 1, 1, 1, "R3 post 0");
    idle(1, 1, 1, "R8 lowest 0");
    idle(1, 1, 0, "R6 u off");
    step(0, 0, 1, 0, 0, 0, '0, 0, '0, 1, 1, 1, "R3 clear 0");
    idle(1, 1, 1, "R8 after clear 0");
    // R3 precedence: clear beats post, post beats clear-all
    step(1, 4, 1, 4, 0, 0, '0, 0, '0, 1, 1, 1, "R3 clear beats post");
    step(1, 9, 0, 0, 1, 0, '0, 0, '0, 1, 1, 1, "R3 post beats clear-all");
    idle(1, 1, 1, "R8 only 9");
    // R5: pending write with strobes in the same cycle
    step(1, 5, 1, 8, 0, 1, 12'h900, 0, '0, 1, 1, 1, "R5 write plus strobes");
    idle(1, 1, 1, "R8 lowest 5");
    step(0, 0, 0, 0, 0, 1, 12'hFFF, 0, '0, 1, 1, 1, "R2 R4 ip write all");
    idle(1, 1, 1, "R8 lowest 0 again");
    // R7: enable write masks everything
    step(0, 0, 0, 0, 0, 0, '0, 1, 12'h800, 1, 1, 1, "R4 ie narrow");
    idle(1, 1, 1, "R7 only 11");
    idle(0, 1, 1, "R7 m off none");
    idle(0, 1, 1, "R8 none cause 0");
    step(0, 0, 0, 0, 1, 0, '0, 0, '0, 1, 1, 1, "R3 clear-all");
    idle(1, 1, 1, "R7 nothing pending");
    idle(1, 1, 1, "R7 final");
    wait (sbq.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule